// File: doc/BRIEF.md
# Center-Aligned Three-Phase Complementary PWM Generator

This block drives the six gates of a three-phase inverter bridge from one up/down counter. The counter sweeps from zero up to a programmed half-period value and back, and each leg compares it against its own duty value. The comparison produces a top/bottom pair, separated by a programmed dead time. The top gate of each leg can be given inverted polarity, so that a driver that turns its high-side device on with a low level can be attached directly.

Duty values on the input ports act as a buffer. They reach the comparators only at a reload point, and only once a load-OK request is pending, so a controller can write three duties and commit them together. Reload points can fall on every Nth opportunity. An opportunity is a period start, plus the period midpoint when half-cycle reload is on. A sync pulse for downstream sampling logic goes out only with a reload that falls on a period start.

A fault pin passes through a digital filter into a sticky flag. The flag forces every gate to its off level until it is cleared.

Top module: `cpwm3_gen`

## Requirements
- R1: While reset is held, the fault flag is clear, every top gate sits at its off level, and every bottom gate is off whenever the dead time is nonzero. Until the first duty transfer, each leg uses duty = floor(modulus/2). Over one period the top gate is therefore active for 2*floor(modulus/2)-1-dead cycles, and the bottom gate for 2*modulus-(2*floor(modulus/2)-1)-dead cycles.
- R2: The counter is 0 in the first cycle after reset. It then steps by one up to the modulus and back down to 1, so a period lasts 2*modulus cycles. A leg's raw command is "counter < duty". The gates follow that command one clock later. Duty 0 keeps the top gate off, and a duty above the modulus keeps it on.
- R3: reload_o pulses for one cycle on each reload point. Opportunities are counted from reset, and the first one is a reload. After that, a reload occurs on every (rld_sel_i+1)th opportunity.
- R4: When half_i is 0, only the counter value 0 is an opportunity. When half_i is 1, the cycle in which the counter equals the modulus is an opportunity as well.
- R5: sync_o is high only in a cycle where reload_o is high and the counter is 0. It is never high at a midpoint reload.
- R6: ldok_i sets a pending flag. On a reload with the flag pending, all three duties are copied from duty_i, and the flag clears. If ldok_i is high in that same cycle, the flag stays set. Changes on duty_i at any other time have no effect on the gates.
- R7: A gate turns on only after its raw command has held the matching level for dead_i+1 consecutive clocks. It turns off on the first clock after the command leaves that level. The top and bottom gates of a leg are never active together.
- R8: When top_inv_i[l] is 1, top_o[l] is low when that gate is active. Bottom gates are always active high.
- R9: The fault flag sets on the clock edge at which fault_i has been sampled high for FLT_LEN consecutive edges. A shorter high pulse has no effect.
- R10: The fault flag stays set until a cycle in which fault_clr_i is high and the set condition of R9 is not met.
- R11: While fault_o is 1, every top_o[l] equals top_inv_i[l] and every bottom_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_i | input | CNT_W | Half-period count (counter peak) |
| duty_i | input | 3*CNT_W | Buffered duties, leg l in bits l*CNT_W +: CNT_W |
| dead_i | input | DT_W | Dead time in clocks |
| rld_sel_i | input | RLD_W | Reload on every (value+1)th opportunity |
| half_i | input | 1 | Treat the period midpoint as an opportunity |
| ldok_i | input | 1 | Request transfer of duty_i at the next reload |
| top_inv_i | input | 3 | Per-leg inverted top polarity |
| fault_i | input | 1 | Active-high fault pin |
| fault_clr_i | input | 1 | Clear the sticky fault flag |
| top_o | output | 3 | Top gate per leg |
| bot_o | output | 3 | Bottom gate per leg |
| reload_o | output | 1 | Reload pulse |
| sync_o | output | 1 | Start-of-period sync pulse |
| fault_o | output | 1 | Sticky fault flag |

## Verification
A counter that has slipped by one step moves the reload pulse off its expected cycle at the very next opportunity. It also shifts every gate edge within one period. A wrong opportunity count shows as a missing or extra reload or sync pulse within N opportunities. A stale or early duty copy changes the active-cycle count of a leg in the period right after the reload.

Dead-time and filter counters that are off by one move a single gate or flag edge by one clock. The bench therefore compares all outputs in every cycle against a model derived from the sample history, rather than sampling only at selected points.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  localparam int unsigned NUM_LEGS = 3;

  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;

  typedef struct packed {
    logic top;
    logic bot;
  } gate_t;
endpackage

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RLD_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [RLD_W-1:0] rld_sel_i,
  input  logic             half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o,
  output logic             sync_o
);
  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;
  logic [RLD_W-1:0] opp_q;
  logic             start_evt, mid_evt, opp_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q < mod_i) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        dir_q <= (cnt_q > CNT_W'(1)) ? DIR_DN : DIR_UP;
      end
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      dir_q <= (cnt_q > CNT_W'(1)) ? DIR_DN : DIR_UP;
    end
  end

  assign start_evt = (cnt_q == '0);
  assign mid_evt   = (dir_q == DIR_UP) && (cnt_q == mod_i) && (mod_i != '0);
  assign opp_evt   = start_evt || (half_i && mid_evt);

  // opportunity index modulo (rld_sel_i + 1)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opp_q <= '0;
    end else if (opp_evt) begin
      opp_q <= (opp_q >= rld_sel_i) ? '0 : opp_q + 1'b1;
    end
  end

  assign reload_o = opp_evt && (opp_q == '0);
  assign sync_o   = reload_o && start_evt;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/cpwm_leg.sv
`timescale 1ns/1ps
module cpwm_leg
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic             top_inv_i,
  input  logic             force_off_i,
  output gate_t            gate_o
);
  logic            raw;
  logic            cmd_q;
  logic [DT_W-1:0] held_q;
  logic            settled;

  assign raw = (cnt_i < duty_i);

  // held_q: clocks since cmd_q last changed, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= 1'b0;
      held_q <= '0;
    end else begin
      cmd_q <= raw;
      if (raw != cmd_q)    held_q <= '0;
      else if (held_q != '1) held_q <= held_q + 1'b1;
    end
  end

  assign settled = (held_q >= dead_i);

  always_comb begin
    if (force_off_i) begin
      gate_o.top = top_inv_i;
      gate_o.bot = 1'b0;
    end else begin
      gate_o.top = (cmd_q && settled) ^ top_inv_i;
      gate_o.bot = !cmd_q && settled;
    end
  end
endmodule

// File: rtl/cpwm_fault.sv
`timescale 1ns/1ps
module cpwm_fault #(
  parameter int unsigned FLT_LEN = 92
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int unsigned FC_W = $clog2(FLT_LEN + 1);
  localparam logic [FC_W-1:0] LAST = FC_W'(FLT_LEN - 1);

  logic [FC_W-1:0] run_q;
  logic            hit;
  logic            flag_q;

  assign hit = fault_i && (run_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (!fault_i)          run_q <= '0;
      else if (run_q != LAST) run_q <= run_q + 1'b1;
      flag_q <= hit || (flag_q && !clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cpwm3_gen.sv
`timescale 1ns/1ps
module cpwm3_gen
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DT_W    = 8,
  parameter int unsigned RLD_W   = 2,
  parameter int unsigned FLT_LEN = 92
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          mod_i,
  input  logic [NUM_LEGS*CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]           dead_i,
  input  logic [RLD_W-1:0]          rld_sel_i,
  input  logic                      half_i,
  input  logic                      ldok_i,
  input  logic [NUM_LEGS-1:0]       top_inv_i,
  input  logic                      fault_i,
  input  logic                      fault_clr_i,
  output logic [NUM_LEGS-1:0]       top_o,
  output logic [NUM_LEGS-1:0]       bot_o,
  output logic                      reload_o,
  output logic                      sync_o,
  output logic                      fault_o
);
  logic [CNT_W-1:0] cnt;
  logic             reload;
  logic             ldok_q, loaded_q, xfer;
  logic             flag;

  cpwm_timebase #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mod_i     (mod_i),
    .rld_sel_i (rld_sel_i),
    .half_i    (half_i),
    .cnt_o     (cnt),
    .reload_o  (reload),
    .sync_o    (sync_o)
  );

  cpwm_fault #(.FLT_LEN(FLT_LEN)) u_flt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_i),
    .clr_i   (fault_clr_i),
    .flag_o  (flag)
  );

  assign xfer = reload && ldok_q;

  // a new request in the transfer cycle stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldok_q   <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      if (ldok_i)    ldok_q <= 1'b1;
      else if (xfer) ldok_q <= 1'b0;
      if (xfer) loaded_q <= 1'b1;
    end
  end

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] duty_eff;
    gate_t            gate;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   duty_q <= '0;
      else if (xfer) duty_q <= duty_i[l*CNT_W +: CNT_W];
    end

    // half-modulus until the first commit: zero line-to-line voltage
    assign duty_eff = loaded_q ? duty_q : (mod_i >> 1);

    cpwm_leg #(.CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cnt_i       (cnt),
      .duty_i      (duty_eff),
      .dead_i      (dead_i),
      .top_inv_i   (top_inv_i[l]),
      .force_off_i (flag),
      .gate_o      (gate)
    );

    assign top_o[l] = gate.top;
    assign bot_o[l] = gate.bot;
  end

  assign reload_o = reload;
  assign fault_o  = flag;
endmodule

// File: rtl/cpwm3_gen_chk.sv
`timescale 1ns/1ps
module cpwm3_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] mod_i,
  input logic [2:0]       top_inv_i,
  input logic             fault_i,
  input logic             fault_clr_i,
  input logic [2:0]       top_o,
  input logic [2:0]       bot_o,
  input logic             reload_o,
  input logic             sync_o,
  input logic             fault_o
);
  // R7
  no_shoot_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((top_o ^ top_inv_i) & bot_o) == 3'b000);

  // R5
  sync_with_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> reload_o);

  // R3
  reload_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_o && mod_i > CNT_W'(1)) |=> !reload_o);

  // R11
  fault_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (bot_o == 3'b000 && top_o == top_inv_i));

  // R10
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);

  // R9
  fault_needs_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(fault_i));
endmodule

bind cpwm3_gen cpwm3_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cpwm3_gen_bench.sv
`timescale 1ns/1ps
module cpwm3_gen_bench;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int RW = 2;
  localparam int FL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] mod = 8'd6;
  logic [3*CW-1:0] duty = '0;
  logic [DW-1:0] dead = '0;
  logic [RW-1:0] sel = '0;
  logic          half = 1'b0, ldok = 1'b0, flt = 1'b0, clr = 1'b0;
  logic [2:0]    inv = '0;
  logic [2:0]    top, bot;
  logic          rld, syn, fo;

  int checks = 0, fails = 0;
  int k;
  bit hist [3][0:4095];
  bit fh [0:4095];
  int m_opp;
  bit m_ldok, m_loaded, m_flag;
  int m_duty [3];
  bit win;
  int ct [3];
  int cb [3];

  cpwm3_gen #(.CNT_W(CW), .DT_W(DW), .RLD_W(RW), .FLT_LEN(FL)) u_cpwm3_gen (
    .clk_i(clk), .rst_ni(rst_n), .mod_i(mod), .duty_i(duty), .dead_i(dead),
    .rld_sel_i(sel), .half_i(half), .ldok_i(ldok), .top_inv_i(inv),
    .fault_i(flt), .fault_clr_i(clr), .top_o(top), .bot_o(bot),
    .reload_o(rld), .sync_o(syn), .fault_o(fo)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (cycle %0d): got %0d expected %0d", tag, k, got, exp);
    end
  endtask

  // raw command history; before reset the command reads as "just changed to 0"
  function automatic bit rawh(input int l, input int i);
    if (i >= 0) return hist[l][i];
    return (i == -1) ? 1'b0 : 1'b1;
  endfunction

  function automatic bit fhist(input int i);
    return (i >= 0) ? fh[i] : 1'b0;
  endfunction

  task automatic step();
    int md, p, c, eff;
    bit st, mid, ev, erl, esy, ta, tb, et, eb, hit, xf;
    md  = int'(mod);
    p   = k % (2 * md);
    c   = (p <= md) ? p : 2 * md - p;
    st  = (p == 0);
    mid = (p == md);
    ev  = st || (half && mid);
    erl = ev && ((m_opp % (int'(sel) + 1)) == 0);
    esy = erl && st;
    check(rld == erl, "R3 R4 reload_o", int'(rld), int'(erl));
    check(syn == esy, "R5 sync_o", int'(syn), int'(esy));
    for (int l = 0; l < 3; l++) begin
      eff = m_loaded ? m_duty[l] : md / 2;
      hist[l][k] = (c < eff);
      ta = 1'b1; tb = 1'b1;
      for (int j = 0; j <= int'(dead); j++) begin
        if (rawh(l, k - 1 - j) != 1'b1) ta = 1'b0;
        if (rawh(l, k - 1 - j) != 1'b0) tb = 1'b0;
      end
      et = m_flag ? inv[l] : (ta ^ inv[l]);
      eb = !m_flag && tb;
      check(top[l] == et, $sformatf("R2 R6 R7 R8 R11 top leg %0d", l), int'(top[l]), int'(et));
      check(bot[l] == eb, $sformatf("R2 R6 R7 R11 bottom leg %0d", l), int'(bot[l]), int'(eb));
      if (win) begin
        ct[l] += int'(top[l] ^ inv[l]);
        cb[l] += int'(bot[l]);
      end
    end
    check(fo == m_flag, "R9 R10 fault_o", int'(fo), int'(m_flag));
    // advance model to the next edge
    fh[k] = flt;
    hit = 1'b1;
    for (int j = 0; j < FL; j++) if (!fhist(k - j)) hit = 1'b0;
    m_flag = hit || (m_flag && !clr);
    if (ev) m_opp++;
    xf = erl && m_ldok;
    if (xf) begin
      for (int l = 0; l < 3; l++) m_duty[l] = int'(duty[l*CW +: CW]);
      m_loaded = 1'b1;
    end
    m_ldok = ldok ? 1'b1 : (xf ? 1'b0 : m_ldok);
    k++;
    @(negedge clk);
  endtask

  task automatic run_cfg(input int md, input int dt, input int s, input bit h,
                         input bit [2:0] iv, input int da, input int db, input int dc);
    int d;
    rst_n = 1'b0;
    mod = CW'(md); dead = DW'(dt); sel = RW'(s); half = h; inv = iv;
    ldok = 1'b0; flt = 1'b0; clr = 1'b0;
    duty = {CW'(dc), CW'(db), CW'(da)};
    repeat (2) @(negedge clk);
    // R1 reset state
    check(fo == 1'b0, "R1 reset fault_o", int'(fo), 0);
    check(top == iv, "R1 reset top_o", int'(top), int'(iv));
    check(bot == ((dt == 0) ? 3'b111 : 3'b000), "R1 reset bot_o", int'(bot),
          (dt == 0) ? 7 : 0);
    k = 0; m_opp = 0; m_ldok = 1'b0; m_loaded = 1'b0; m_flag = 1'b0; win = 1'b0;
    rst_n = 1'b1;
    // duty_i is ignored without load-OK (R6)
    repeat (4 * md) step();
    for (int l = 0; l < 3; l++) begin ct[l] = 0; cb[l] = 0; end
    win = 1'b1;
    repeat (2 * md) step();
    win = 1'b0;
    d = md / 2;
    for (int l = 0; l < 3; l++) begin
      check(ct[l] == 2 * d - 1 - dt, $sformatf("R1 default top count leg %0d", l), ct[l], 2 * d - 1 - dt);
      check(cb[l] == 2 * md - (2 * d - 1) - dt, $sformatf("R1 default bottom count leg %0d", l),
            cb[l], 2 * md - (2 * d - 1) - dt);
    end
    ldok = 1'b1; step(); ldok = 1'b0;
    repeat (6 * md) step();
    // second commit: the value present at the reload edge is taken (R6)
    duty = {CW'(da), CW'(dc), CW'(db)};
    ldok = 1'b1; step(); ldok = 1'b0;
    duty = {CW'(1), CW'(0), CW'(md + 1)};
    repeat (6 * md) step();
    // fault filter: short pulse ignored, long pulse latches (R9)
    flt = 1'b1; repeat (FL - 1) step(); flt = 1'b0;
    repeat (5) step();
    flt = 1'b1; repeat (FL + 1) step(); flt = 1'b0;
    repeat (6) step();
    clr = 1'b1; step(); clr = 1'b0;
    repeat (4) step();
    // clear while the pin is still held high (R10)
    flt = 1'b1; repeat (FL + 2) step();
    clr = 1'b1; step(); clr = 1'b0;
    repeat (3) step();
    flt = 1'b0; repeat (3) step();
    clr = 1'b1; step(); clr = 1'b0;
    repeat (4 * md) step();
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired: got 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    run_cfg(6, 1, 0, 1'b0, 3'b101, 2, 6, 0);
    run_cfg(5, 2, 1, 1'b1, 3'b000, 1, 5, 3);
    run_cfg(4, 0, 2, 1'b0, 3'b111, 4, 2, 0);
    run_cfg(7, 3, 3, 1'b1, 3'b010, 7, 0, 3);
    run_cfg(6, 1, 0, 1'b1, 3'b001, 3, 1, 6);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule